// File: doc/BRIEF.md
# Bus Response Bit Serializer

This block sends a slave's reply to a bus master one bit per master-driven bit slot. A response word is handed over through a valid/ready interface and held until the next frame on the bus begins. During that frame the master drives a three-level bus: idle, signal-high and signal-low. Each time the bus falls from signal-high to signal-low, the block presents the next reply bit on a current-sink enable. There is no local bit clock. The master's own transitions pace every bit, so the reply follows whatever bit rate the master uses.

A reply is either long or short. A long reply is the 16-bit word followed by a 4-bit CRC, 20 bits in all. A short reply is the low byte of the word followed by a 4-bit CRC, 12 bits in all. The block computes the CRC itself. When the bus goes back to idle, the sink is released at once and a one-cycle done pulse marks the end of the frame. The bus level enters through a synchronizer, so the bus may be asynchronous to the block clock.

Back-pressure works as follows. The holding stage is one word deep. `rsp_ready` is high exactly when no word is held. A word is taken on a cycle with both `rsp_valid` and `rsp_ready` high. The held word is consumed when the next frame starts, and `rsp_ready` then rises again. A word offered while `rsp_ready` is low is not taken and has no effect.

Top module: `rsp_bit_serializer`

## Requirements
- R1: After reset, `sink_en` is 0, `rsp_done` is 0 and `rsp_ready` is 1.
- R2: `rsp_ready` is 1 exactly when no word is held. A word is captured when `rsp_valid` and `rsp_ready` are both 1, and `rsp_ready` is 0 on the next cycle. A word offered while `rsp_ready` is 0 is ignored: the reply sent is still the word held. The held word is consumed when the next frame starts, after which `rsp_ready` returns to 1.
- R3: The `bus_lvl` encoding is 2'b00 idle, 2'b01 signal-high, 2'b10 signal-low, and 2'b11 treated as idle. A frame starts when the level leaves idle. The first signal-high to signal-low fall of the frame presents the first (most significant) reply bit.
- R4: Each later signal-high to signal-low fall in the same frame presents the next reply bit.
- R5: A presented bit of 1 drives `sink_en` to 1 and a bit of 0 drives it to 0. The value holds through the following signal-high until the next fall.
- R6: `sink_en` is 0 whenever the synchronized level is idle. A return to idle ends the reply.
- R7: A long reply (`rsp_long`=1) is `rsp_word[15:0]` MSB first, then the 4-bit CRC MSB first: 20 bits.
- R8: A short reply (`rsp_long`=0) is `rsp_word[7:0]` MSB first, then the 4-bit CRC MSB first: 12 bits. `rsp_word[15:8]` is ignored.
- R9: The CRC register starts at 4'b1010. For each data bit in transmission order, feedback = CRC[3] xor bit, the register shifts left by one, and it is xored with 4'b0011 when the feedback is 1 (polynomial x^4+x+1).
- R10: Falls beyond the reply length, and every fall of a frame that started with no word held, leave `sink_en` at 0.
- R11: A change on `bus_lvl` passes through two synchronizer flops and one edge register. A fall shows on `sink_en` after the third rising clock edge following the change. A return to idle clears `sink_en` after the second edge.
- R12: `rsp_done` pulses high for exactly one cycle after a frame that carried a held word returns to idle. A frame with no word held gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_lvl | input | 2 | Raw three-level bus state, asynchronous |
| rsp_valid | input | 1 | Reply word offered |
| rsp_ready | output | 1 | Holding stage empty |
| rsp_word | input | 16 | Reply word: high byte in [15:8], low byte in [7:0] |
| rsp_long | input | 1 | 1 = long reply, 0 = short reply |
| sink_en | output | 1 | Response current-sink enable |
| rsp_done | output | 1 | One-cycle pulse at the end of a reply frame |

## Verification
On every cycle, the assertions check four things:
- the sink is released whenever the synchronized bus is idle or no reply is in progress;
- the sink can only switch on in the cycle after a detected fall;
- `rsp_done` is never wider than one cycle;
- `rsp_ready` drops after a handshake.

The bit order, the CRC value, the short/long layout, the ignored high byte, the rejected second offer and the exact synchronizer latency can only be shown by the bench's scenarios. In those scenarios the bench compares every presented bit against a frame it builds itself.

// File: rtl/rsp_ser_pkg.sv
package rsp_ser_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_LOW  = 2'b10,
    LVL_RSVD = 2'b11
  } bus_lvl_e;

  function automatic logic lvl_is_idle(input logic [1:0] l);
    return (l == LVL_IDLE) || (l == LVL_RSVD);
  endfunction
endpackage

// File: rtl/rsp_lvl_sync.sv
module rsp_lvl_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_raw,
  output logic       lvl_idle,
  output logic       frame_start,
  output logic       frame_end,
  output logic       fall
);
  import rsp_ser_pkg::*;

  logic [1:0] stg [SYNC_STAGES];
  logic [1:0] prev_q;
  logic [1:0] cur;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= LVL_IDLE;
          else        stg[g] <= lvl_raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= LVL_IDLE;
          else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign cur = stg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= LVL_IDLE;
    else        prev_q <= cur;

  assign lvl_idle    = lvl_is_idle(cur);
  assign frame_start = lvl_is_idle(prev_q) && !lvl_is_idle(cur);
  assign frame_end   = !lvl_is_idle(prev_q) && lvl_is_idle(cur);
  assign fall        = (prev_q == LVL_HIGH) && (cur == LVL_LOW);
endmodule

// File: rtl/rsp_crc4.sv
module rsp_crc4 #(
  parameter int          DATA_W  = 16,
  parameter int          SHORT_W = 8,
  parameter int          CRC_W   = 4,
  parameter logic [3:0]  POLY    = 4'b0011,
  parameter logic [3:0]  SEED    = 4'b1010
) (
  input  logic [DATA_W-1:0] word,
  input  logic              long_i,
  output logic [CRC_W-1:0]  crc
);
  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c  = SEED[CRC_W-1:0];
    fb = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (long_i || i < SHORT_W) begin
        fb = c[CRC_W-1] ^ word[i];
        c  = {c[CRC_W-2:0], 1'b0};
        if (fb) c = c ^ POLY[CRC_W-1:0];
      end
    end
    crc = c;
  end
endmodule

// File: rtl/rsp_shifter.sv
module rsp_shifter #(
  parameter int FRAME_W = 20,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [CNT_W-1:0]   load_len,
  input  logic               shift,
  input  logic               clear,
  output logic               bit_q,
  output logic               active
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      bit_q  <= 1'b0;
      active <= 1'b0;
    end else if (clear) begin
      left_q <= '0;
      bit_q  <= 1'b0;
      active <= 1'b0;
    end else if (load) begin
      sh_q   <= load_frame;
      left_q <= load_len;
      bit_q  <= 1'b0;
      active <= 1'b1;
    end else if (shift) begin
      if (left_q != '0) begin
        bit_q  <= sh_q[FRAME_W-1];
        sh_q   <= sh_q << 1;
        left_q <= left_q - CNT_W'(1);
      end else begin
        bit_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsp_bit_serializer.sv
module rsp_bit_serializer #(
  parameter int         DATA_W      = 16,
  parameter int         SHORT_W     = 8,
  parameter int         CRC_W       = 4,
  parameter logic [3:0] CRC_SEED    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_lvl,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_word,
  input  logic              rsp_long,
  output logic              sink_en,
  output logic              rsp_done
);
  localparam int LONG_LEN  = DATA_W + CRC_W;
  localparam int SHORT_LEN = SHORT_W + CRC_W;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);

  logic lvl_idle, frame_start, frame_end, fall;
  logic held_q, held_long_q, active, bit_q, done_q;
  logic [DATA_W-1:0]   held_word_q;
  logic [CRC_W-1:0]    crc;
  logic [LONG_LEN-1:0] frame;
  logic [CNT_W-1:0]    frame_len;

  rsp_lvl_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lvl_raw(bus_lvl), .lvl_idle(lvl_idle),
    .frame_start(frame_start), .frame_end(frame_end), .fall(fall)
  );

  rsp_crc4 #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .CRC_W(CRC_W),
             .POLY(4'b0011), .SEED(CRC_SEED)) u_crc (
    .word(held_word_q), .long_i(held_long_q), .crc(crc)
  );

  assign rsp_ready = !held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      held_long_q <= 1'b0;
      held_word_q <= '0;
    end else if (rsp_valid && rsp_ready) begin
      held_q      <= 1'b1;
      held_long_q <= rsp_long;
      held_word_q <= rsp_word;
    end else if (frame_start && held_q) begin
      held_q      <= 1'b0;
    end
  end

  always_comb begin
    if (held_long_q) begin
      frame     = {held_word_q, crc};
      frame_len = CNT_W'(LONG_LEN);
    end else begin
      frame     = {held_word_q[SHORT_W-1:0], crc, {(DATA_W-SHORT_W){1'b0}}};
      frame_len = CNT_W'(SHORT_LEN);
    end
  end

  rsp_shifter #(.FRAME_W(LONG_LEN), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(frame_start && held_q),
    .load_frame(frame), .load_len(frame_len), .shift(fall),
    .clear(frame_end), .bit_q(bit_q), .active(active)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= frame_end && active;

  assign rsp_done = done_q;
  assign sink_en  = bit_q && !lvl_idle;
endmodule

// File: rtl/rsp_ser_chk.sv
module rsp_ser_chk (
  input logic clk,
  input logic rst_n,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic sink_en,
  input logic rsp_done,
  input logic lvl_idle,
  input logic fall,
  input logic active
);
  a_r6_idle_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_idle |-> !sink_en);

  a_r10_no_reply_no_sink: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sink_en);

  a_r5_rise_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> !$rose(sink_en));

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_ready);
endmodule

bind rsp_bit_serializer rsp_ser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .sink_en(sink_en), .rsp_done(rsp_done), .lvl_idle(lvl_idle),
  .fall(fall), .active(active)
);

// File: tb/rsp_bit_serializer_tb.sv
module rsp_bit_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_lvl = 2'b00;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [15:0] rsp_word = '0;
  logic        rsp_long = 1'b0;
  logic        sink_en;
  logic        rsp_done;

  int errs = 0;
  int checks = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rsp_bit_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_long(rsp_long),
    .sink_en(sink_en), .rsp_done(rsp_done)
  );

  always @(posedge clk) if (rsp_done) done_cnt <= done_cnt + 1;

  // {long flag, word}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 16'hA5C3}, {1'b0, 16'hBE81}, {1'b1, 16'h0000},
    {1'b0, 16'h00FF}, {1'b1, 16'hFFFF}, {1'b0, 16'h3C01}
  };

  function automatic logic [19:0] model_frame(input logic [15:0] w, input logic lng);
    logic [3:0] c = 4'b1010;
    logic fb;
    int n = lng ? 16 : 8;
    for (int i = n - 1; i >= 0; i--) begin
      fb = c[3] ^ w[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    end
    return lng ? {w, c} : {w[7:0], c, 8'h00};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] l, input int n);
    bus_lvl = l;
    repeat (n) @(negedge clk);
  endtask

  task automatic stage(input logic [15:0] w, input logic lng);
    rsp_valid = 1'b1; rsp_word = w; rsp_long = lng;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  // slots = number of high->low bit slots; word staged beforehand if have_word
  task automatic run_frame(input logic [15:0] w, input logic lng, input logic have_word,
                           input int slots);
    logic [19:0] fr = model_frame(w, lng);
    int len = lng ? 20 : 12;
    int dl = lng ? 16 : 8;
    int d0 = done_cnt;
    logic e;
    string tg;
    drive(2'b01, 4);
    chk(rsp_ready == 1'b1, "R2 ready after frame start", rsp_ready, 1);
    for (int s = 0; s < slots; s++) begin
      drive(2'b10, 4);
      e = (have_word && s < len) ? fr[19-s] : 1'b0;
      if (!have_word || s >= len) tg = "R10";
      else if (s >= dl) tg = "R9";
      else tg = lng ? "R7" : "R8";
      chk(sink_en == e, $sformatf("%s %s slot %0d", tg, (s == 0) ? "R3" : "R4", s), sink_en, e);
      drive(2'b01, 4);
      chk(sink_en == e, $sformatf("R5 hold slot %0d", s), sink_en, e);
    end
    drive(2'b00, 4);
    chk(sink_en == 1'b0, "R6 idle off", sink_en, 0);
    chk(done_cnt == d0 + (have_word ? 1 : 0), "R12 done count", done_cnt - d0, have_word ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog all requirements act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sink_en == 1'b0, "R1 sink in reset", sink_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sink_en == 1'b0, "R1 sink", sink_en, 0);
    chk(rsp_done == 1'b0, "R1 done", rsp_done, 0);
    chk(rsp_ready == 1'b1, "R1 ready", rsp_ready, 1);

    // vector table
    for (int v = 0; v < 6; v++) begin
      stage(VEC[v][15:0], VEC[v][16]);
      chk(rsp_ready == 1'b0, "R2 ready low while held", rsp_ready, 0);
      run_frame(VEC[v][15:0], VEC[v][16], 1'b1, (VEC[v][16] ? 20 : 12) + 2);
    end

    // R10: frame without staged word
    run_frame(16'hFFFF, 1'b1, 1'b0, 3);

    // R2: offer while held is ignored
    stage(16'h8001, 1'b1);
    stage(16'h7FFE, 1'b0);
    run_frame(16'h8001, 1'b1, 1'b1, 20);

    // R11 / R6 latency with first bit 1
    stage(16'hFFFF, 1'b1);
    drive(2'b01, 4);
    bus_lvl = 2'b10;
    repeat (2) @(negedge clk);
    chk(sink_en == 1'b0, "R11 not yet after 2 edges", sink_en, 0);
    @(negedge clk);
    chk(sink_en == 1'b1, "R11 shown after 3 edges", sink_en, 1);
    @(negedge clk);
    bus_lvl = 2'b00;
    @(negedge clk);
    chk(sink_en == 1'b1, "R11 still on after 1 edge of idle", sink_en, 1);
    @(negedge clk);
    chk(sink_en == 1'b0, "R6 off after 2 edges of idle", sink_en, 0);
    repeat (4) @(negedge clk);

    // R3: reserved code 2'b11 acts as idle and ends frame
    stage(16'hFFFF, 1'b1);
    drive(2'b01, 4);
    drive(2'b10, 4);
    chk(sink_en == 1'b1, "R3 first bit", sink_en, 1);
    drive(2'b11, 4);
    chk(sink_en == 1'b0, "R3 code 11 as idle", sink_en, 0);
    drive(2'b00, 4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule